// File: doc/BRIEF.md
# Multiplexed GPIO Register Bank

This block is a memory-mapped controller for 54 general-purpose pins. The pins are split into a low bank (pins 0 to 31) and a high bank (pins 32 to 53). Each pin has a 3-bit function code. The code is held in packed select registers and passed out to an external pad multiplexer. The block keeps an output latch for every pin, which software drives through write-one-to-set and write-one-to-clear registers. It also lets software read back the synchronized input level of every pin.

Each bank has four independent detect-enable registers: rising edge, falling edge, high level and low level. Any enabled condition on a pin latches a sticky event bit. Software clears an event bit by writing a one to it. Pad drivers, pull resistors and the alternate peripherals sit outside the block. The block drives only a per-pin output value, a per-pin output enable and the per-pin function code.

Access is through a simple register bus. A one-cycle select pulse carries a write or a read. The ready flag and the read data come back registered, one cycle later.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset every function code is 000, pin_oe and pin_out are all zero, and every detect-enable and event-status register reads zero.
- R2: The function code of pin n sits in the select register at byte offset 4*(n/10), bits 3*(n mod 10)+2 down to 3*(n mod 10). Select registers 0x00 to 0x14 read back what was written. Bits with no pin behind them (bits 30 and 31, and bits 12 to 31 of the register at 0x14) read zero. The code of pin n appears on pin_func[3n+2:3n].
- R3: Writing to the set register (0x18 for the low bank, 0x1C for the high bank) drives pin_out high for each pin whose data bit is one. Zero bits leave the pin unchanged.
- R4: Writing to the clear register (0x20 for the low bank, 0x24 for the high bank) drives pin_out low for each pin whose data bit is one. Zero bits leave the pin unchanged.
- R5: Code 001 selects output and is the only code that raises pin_oe. Code 000 is input. The alternate codes are 100 (alt 0), 101 (alt 1), 110 (alt 2), 111 (alt 3), 011 (alt 4) and 010 (alt 5). These codes leave pin_oe low and are passed unchanged on pin_func.
- R6: In every high-bank register, bits 22 to 31 read zero, and writes to them have no effect.
- R7: The level registers (0x28 low bank, 0x2C high bank) return the pin inputs after a two-flop synchronizer. A read issued in the cycle an input changes, or in the next cycle, still returns the old level. A read issued in the third cycle returns the new level.
- R8: An enabled rising-edge condition (enable at 0x38/0x3C) or an enabled falling-edge condition (enable at 0x40/0x44) sets the pin's event bit. An edge on a pin without that enable sets nothing.
- R9: An enabled high-level condition (enable at 0x48/0x4C) or an enabled low-level condition (enable at 0x50/0x54) sets the pin's event bit.
- R10: Event bits (0x30 low bank, 0x34 high bank) stay set until a one is written to them. Zero bits in the write, and clearing the enable, leave the bit set.
- R11: If an enabled level condition is still present when its event bit is cleared, the bit reads back set.
- R12: bus_ready is high in the cycle after each bus_sel pulse. For a read, bus_rdata is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_ready | output | 1 | Access complete, one cycle after bus_sel |
| pin_in | input | 54 | Raw pin input levels |
| pin_out | output | 54 | Output latch value per pin |
| pin_oe | output | 54 | Output enable per pin |
| pin_func | output | 162 | 3-bit function code per pin for the external mux |

## Verification
The bench places codes at field boundaries: pin 10 (the first field of a register), pin 19 (the last field) and pins 50 to 53 (a partly filled register). A design that used the wrong divide or shift would move codes onto the wrong pin, or leak them into bits that must read zero. It steps through all eight codes on one pin, so a decoder that treated any alternate code as output would be caught. It writes all-ones to the high bank, so a design that kept bits 22 to 31 would read them back. It samples the level register in the first three cycles after an input change, which exposes a synchronizer one stage too short or too long. It raises an edge on a pin with only the opposite edge enabled, writes zero bits to the status register, and clears a bit while a high-level condition persists. A design that mixed up edge polarity, treated the status register as plain write, or let a live level condition be cleared would fail these checks.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int FUNC_W        = 3;
  localparam int PINS_PER_FSEL = 10;
  localparam int BANK_W        = 32;

  typedef enum logic [2:0] {
    FN_IN   = 3'b000,
    FN_OUT  = 3'b001,
    FN_ALT5 = 3'b010,
    FN_ALT4 = 3'b011,
    FN_ALT0 = 3'b100,
    FN_ALT1 = 3'b101,
    FN_ALT2 = 3'b110,
    FN_ALT3 = 3'b111
  } func_code_e;

  // byte offsets; each high-bank register sits 4 bytes above its low-bank twin
  localparam logic [7:0] OFF_FSEL  = 8'h00;
  localparam logic [7:0] OFF_SET   = 8'h18;
  localparam logic [7:0] OFF_CLR   = 8'h20;
  localparam logic [7:0] OFF_LEVEL = 8'h28;
  localparam logic [7:0] OFF_EVENT = 8'h30;
  localparam logic [7:0] OFF_RISE  = 8'h38;
  localparam logic [7:0] OFF_FALL  = 8'h40;
  localparam logic [7:0] OFF_HIGH  = 8'h48;
  localparam logic [7:0] OFF_LOW   = 8'h50;

  function automatic int fsel_reg(input int pin);
    return pin / PINS_PER_FSEL;
  endfunction

  function automatic int fsel_shift(input int pin);
    return FUNC_W * (pin % PINS_PER_FSEL);
  endfunction

  function automatic logic [BANK_W-1:0] detect_hits(
    input logic [BANK_W-1:0] now_lvl,
    input logic [BANK_W-1:0] old_lvl,
    input logic [BANK_W-1:0] en_rise,
    input logic [BANK_W-1:0] en_fall,
    input logic [BANK_W-1:0] en_high,
    input logic [BANK_W-1:0] en_low);
    logic [BANK_W-1:0] up, down;
    up   = now_lvl & ~old_lvl;
    down = ~now_lvl & old_lvl;
    return (en_rise & up) | (en_fall & down) | (en_high & now_lvl) | (en_low & ~now_lvl);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [FUNC_W*PINS_PER_FSEL-1:0] wdata,
  output logic [31:0]                rd_word,
  output logic [FUNC_W*NUM_PINS-1:0] func_flat,
  output logic [NUM_PINS-1:0]        oe
);
  logic [FUNC_W-1:0] func_q [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int REG_IDX = p / PINS_PER_FSEL;
    localparam int SHIFT   = FUNC_W * (p % PINS_PER_FSEL);
    always_ff @(posedge clk) begin
      if (!rst_n)
        func_q[p] <= FN_IN;
      else if (wr_en && idx == IDX_W'(REG_IDX))
        func_q[p] <= wdata[SHIFT +: FUNC_W];
    end
    assign func_flat[FUNC_W*p +: FUNC_W] = func_q[p];
    assign oe[p] = (func_q[p] == FN_OUT);
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (idx == IDX_W'(fsel_reg(p)))
        rd_word[fsel_shift(p) +: FUNC_W] = func_q[p];
    end
  end

  // R2: codes change only on a select-register write
  p_fsel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(func_flat));
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl,
  input  logic [3:0]       cfg_we,     // 0 rise, 1 fall, 2 high, 3 low
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [31:0]      rise_rd,
  output logic [31:0]      fall_rd,
  output logic [31:0]      high_rd,
  output logic [31:0]      low_rd,
  output logic [31:0]      status_rd
);
  logic [WIDTH-1:0] rise_q, fall_q, high_q, low_q, prev_q, status_q;
  logic [WIDTH-1:0] hits, clr_mask;
  logic [BANK_W-1:0] hits_full;

  assign hits_full = detect_hits(BANK_W'(lvl), BANK_W'(prev_q), BANK_W'(rise_q),
                                 BANK_W'(fall_q), BANK_W'(high_q), BANK_W'(low_q));
  assign hits     = hits_full[WIDTH-1:0];
  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q   <= '0;
      fall_q   <= '0;
      high_q   <= '0;
      low_q    <= '0;
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q <= lvl;
      if (cfg_we[0]) rise_q <= wdata;
      if (cfg_we[1]) fall_q <= wdata;
      if (cfg_we[2]) high_q <= wdata;
      if (cfg_we[3]) low_q  <= wdata;
      status_q <= (status_q & ~clr_mask) | hits;
    end
  end

  assign rise_rd   = 32'(rise_q);
  assign fall_rd   = 32'(fall_q);
  assign high_rd   = 32'(high_q);
  assign low_rd    = 32'(low_q);
  assign status_rd = 32'(status_q);

  // R10: without a clear write, set event bits stay set
  p_status_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8: every detected condition lands in the status register
  p_hit_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits) |=> ((status_q & $past(hits)) == $past(hits)));

  // R11: a live enabled high level wins over a clear
  p_level_reasserts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(high_q & lvl)) |=> ((status_q & $past(high_q & lvl)) == $past(high_q & lvl)));
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       bus_ready,
  input  logic [NUM_PINS-1:0]        pin_in,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe,
  output logic [FUNC_W*NUM_PINS-1:0] pin_func
);
  localparam int HI_W      = NUM_PINS - BANK_W;
  localparam int FSEL_REGS = (NUM_PINS + PINS_PER_FSEL - 1) / PINS_PER_FSEL;
  localparam int IDX_W     = $clog2(FSEL_REGS);
  localparam int FSEL_END  = 4 * FSEL_REGS;

  logic                 acc_wr;
  logic [NUM_PINS-1:0]  lvl_sync;
  logic [NUM_PINS-1:0]  out_q;
  logic [31:0]          fsel_rd, rd_mux, rdata_q;
  logic                 ready_q, fsel_we;
  logic [31:0]          rise_rd [2];
  logic [31:0]          fall_rd [2];
  logic [31:0]          high_rd [2];
  logic [31:0]          low_rd  [2];
  logic [31:0]          stat_rd [2];
  logic [31:0]          lvl_rd  [2];

  assign acc_wr  = bus_sel && bus_wr;
  assign fsel_we = acc_wr && (int'(bus_addr) < FSEL_END) && (bus_addr[1:0] == 2'b00);

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl_sync));

  gpio_fsel_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_fsel (
    .clk(clk), .rst_n(rst_n), .wr_en(fsel_we), .idx(bus_addr[2 +: IDX_W]),
    .wdata(bus_wdata[FUNC_W*PINS_PER_FSEL-1:0]), .rd_word(fsel_rd),
    .func_flat(pin_func), .oe(pin_oe));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int W  = (b == 0) ? BANK_W : HI_W;
    localparam int LO = b * BANK_W;
    logic [3:0] cfg_we;
    always_comb begin
      for (int k = 0; k < 4; k++)
        cfg_we[k] = acc_wr && (bus_addr == ADDR_W'(OFF_RISE + 8 * k + 4 * b));
    end
    gpio_event_unit #(.WIDTH(W)) u_evt (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_sync[LO +: W]), .cfg_we(cfg_we),
      .clr_we(acc_wr && bus_addr == ADDR_W'(OFF_EVENT + 4 * b)),
      .wdata(bus_wdata[W-1:0]),
      .rise_rd(rise_rd[b]), .fall_rd(fall_rd[b]), .high_rd(high_rd[b]),
      .low_rd(low_rd[b]), .status_rd(stat_rd[b]));
    assign lvl_rd[b] = 32'(lvl_sync[LO +: W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (acc_wr) begin
      if (bus_addr == ADDR_W'(OFF_SET))       out_q[BANK_W-1:0]        <= out_q[BANK_W-1:0] | bus_wdata;
      if (bus_addr == ADDR_W'(OFF_SET + 4))   out_q[NUM_PINS-1:BANK_W] <= out_q[NUM_PINS-1:BANK_W] | bus_wdata[HI_W-1:0];
      if (bus_addr == ADDR_W'(OFF_CLR))       out_q[BANK_W-1:0]        <= out_q[BANK_W-1:0] & ~bus_wdata;
      if (bus_addr == ADDR_W'(OFF_CLR + 4))   out_q[NUM_PINS-1:BANK_W] <= out_q[NUM_PINS-1:BANK_W] & ~bus_wdata[HI_W-1:0];
    end
  end
  assign pin_out = out_q;

  always_comb begin
    rd_mux = '0;
    if (int'(bus_addr) < FSEL_END) rd_mux = fsel_rd;
    for (int b = 0; b < 2; b++) begin
      if (bus_addr == ADDR_W'(OFF_LEVEL + 4 * b)) rd_mux = lvl_rd[b];
      if (bus_addr == ADDR_W'(OFF_EVENT + 4 * b)) rd_mux = stat_rd[b];
      if (bus_addr == ADDR_W'(OFF_RISE  + 4 * b)) rd_mux = rise_rd[b];
      if (bus_addr == ADDR_W'(OFF_FALL  + 4 * b)) rd_mux = fall_rd[b];
      if (bus_addr == ADDR_W'(OFF_HIGH  + 4 * b)) rd_mux = high_rd[b];
      if (bus_addr == ADDR_W'(OFF_LOW   + 4 * b)) rd_mux = low_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= bus_sel;
      if (bus_sel && !bus_wr) rdata_q <= rd_mux;
    end
  end
  assign bus_ready = ready_q;
  assign bus_rdata = rdata_q;

  // R12: every access completes one cycle later
  p_ready_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);

  // R3: set bits land high on the pins
  p_set_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && bus_addr == ADDR_W'(OFF_SET)) |=>
      ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R4: clear bits land low on the pins
  p_clr_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && bus_addr == ADDR_W'(OFF_CLR)) |=>
      ((pin_out[BANK_W-1:0] & $past(bus_wdata)) == '0));

  // R6: high-bank reads never show bits above the last pin
  p_hi_bank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr >= ADDR_W'(OFF_LEVEL) && bus_addr[2]) |=>
      (bus_rdata[31:HI_W] == '0));
endmodule

// File: tb/sim_gpio_mux_bank.sv
module sim_gpio_mux_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_ready;
  logic [53:0]  pin_in = '0;
  logic [53:0]  pin_out, pin_oe;
  logic [161:0] pin_func;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_mux_bank u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_func(pin_func));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    chk("R12 ready after write", 64'(bus_ready), 64'd1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, 64'(d), 64'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pin_oe", 64'(pin_oe), 64'd0);
    chk("R1 pin_out", 64'(pin_out), 64'd0);
    chk("R1 pin_func", 64'(pin_func[63:0]), 64'd0);
    rd_chk("R1 fsel0", 8'h00, 32'h0);
    rd_chk("R1 rise enable", 8'h38, 32'h0);
    rd_chk("R1 status", 8'h30, 32'h0);
  endtask

  task automatic t_fsel;
    // pin10 output, pin13 alt0 (100), pin19 alt5 (010)
    wr(8'h04, (32'd1 << 0) | (32'd4 << 9) | (32'd2 << 27));
    chk("R2 pin10 code", 64'(pin_func[30 +: 3]), 64'd1);
    chk("R2 pin13 code", 64'(pin_func[39 +: 3]), 64'd4);
    chk("R2 pin19 code", 64'(pin_func[57 +: 3]), 64'd2);
    chk("R5 pin10 oe", 64'(pin_oe[10]), 64'd1);
    chk("R5 pin13 oe", 64'(pin_oe[13]), 64'd0);
    rd_chk("R2 fsel1 readback", 8'h04, 32'h1000_0801);
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R2 partial fsel5", 8'h14, 32'h0000_0FFF);
    chk("R2 pin53 code", 64'(pin_func[159 +: 3]), 64'd7);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R2 top bits zero", 8'h0C, 32'h3FFF_FFFF);
    chk("R5 alt3 oe low", 64'(pin_oe[39:30]), 64'd0);
    wr(8'h0C, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_codes;
    for (int c = 0; c < 8; c++) begin
      wr(8'h00, 32'(c));
      chk("R5 code on pin_func", 64'(pin_func[2:0]), 64'(c));
      chk("R5 oe only for 001", 64'(pin_oe[0]), 64'(c == 1));
    end
    wr(8'h00, 32'h0);
  endtask

  task automatic t_set_clear;
    wr(8'h18, 32'h0000_0401);
    chk("R3 set low bank", 64'(pin_out[31:0]), 64'h401);
    wr(8'h18, 32'h0);
    chk("R3 zero set no effect", 64'(pin_out[31:0]), 64'h401);
    wr(8'h20, 32'h1);
    chk("R4 clear pin0", 64'(pin_out[31:0]), 64'h400);
    wr(8'h20, 32'h0);
    chk("R4 zero clear no effect", 64'(pin_out[31:0]), 64'h400);
    wr(8'h1C, 32'h5);
    chk("R3 set high bank", 64'(pin_out[53:32]), 64'h5);
    wr(8'h1C, 32'hFFC0_0000);
    chk("R6 unimplemented set ignored", 64'(pin_out[53:32]), 64'h5);
    wr(8'h24, 32'hFFFF_FFFF);
    chk("R4 clear high bank", 64'(pin_out[53:32]), 64'h0);
  endtask

  task automatic t_bank1_mask;
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_chk("R6 high-bank enable width", 8'h3C, 32'h003F_FFFF);
    wr(8'h3C, 32'h0);
    rd_chk("R6 high-bank enable cleared", 8'h3C, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    pin_in[5] = 1'b1;
    rd(8'h28, d); chk("R7 first cycle old", 64'(d[5]), 64'd0);
    rd(8'h28, d); chk("R7 second cycle old", 64'(d[5]), 64'd0);
    rd(8'h28, d); chk("R7 third cycle new", 64'(d[5]), 64'd1);
    pin_in = {22'h15_5555, 32'hA5A5_0003};
    idle(3);
    rd_chk("R7 low bank level", 8'h28, 32'hA5A5_0003);
    rd_chk("R7 high bank level", 8'h2C, 32'h0015_5555);
    pin_in = '0;
    idle(3);
    rd_chk("R8 no event while disabled", 8'h30, 32'h0);
  endtask

  task automatic t_edges;
    wr(8'h38, 32'h8);    // rise on pin 3
    wr(8'h40, 32'h10);   // fall on pin 4
    pin_in[4] = 1'b1; idle(4);
    pin_in[3] = 1'b1; idle(4);
    rd_chk("R8 rise only on enabled pin", 8'h30, 32'h8);
    pin_in[4] = 1'b0; idle(4);
    rd_chk("R8 fall latched", 8'h30, 32'h18);
    wr(8'h30, 32'h0);
    rd_chk("R10 zero write keeps bits", 8'h30, 32'h18);
    wr(8'h30, 32'h8); idle(1);
    rd_chk("R10 one clears, edge not repeated", 8'h30, 32'h10);
    wr(8'h30, 32'h10); idle(1);
    rd_chk("R10 all clear", 8'h30, 32'h0);
    wr(8'h38, 32'h0);
    wr(8'h40, 32'h0);
    pin_in[3] = 1'b0; idle(4);
  endtask

  task automatic t_levels;
    wr(8'h4C, 32'h2);    // high level on pin 33
    pin_in[33] = 1'b1; idle(4);
    rd_chk("R9 high level latched", 8'h34, 32'h2);
    wr(8'h34, 32'h2); idle(1);
    rd_chk("R11 live level re-sets", 8'h34, 32'h2);
    wr(8'h4C, 32'h0); idle(1);
    rd_chk("R10 sticky after disable", 8'h34, 32'h2);
    wr(8'h34, 32'h2); idle(1);
    rd_chk("R10 clear after disable", 8'h34, 32'h0);
    pin_in[33] = 1'b0;
    wr(8'h50, 32'h80);   // low level on pin 7
    idle(2);
    rd_chk("R9 low level latched", 8'h30, 32'h80);
    wr(8'h50, 32'h0);
    wr(8'h30, 32'h80); idle(1);
    rd_chk("R9 low cleared", 8'h30, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_fsel();
    t_codes();
    t_set_clear();
    t_bank1_mask();
    t_level();
    t_edges();
    t_levels();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule